// File: doc/BRIEF.md
# Power-Up Strap Boot Mode Selector

This block decides, once per power-up, how the chip boots. Three strap pins are held at fixed levels by board resistors. The block passes them through a synchroniser and captures them into a register a fixed number of cycles after power-on reset is released. It then decodes the captured code into exactly one boot mode: functional, UART loader or factory restore. It also drives a debug-port select that chooses between a two-wire serial debug port and four-wire JTAG. Once the code is captured, the strap pins are no longer looked at, so board logic can reuse a strap pin as a plain output after boot.

One strap code leaves the choice to the UART receive line. In that mode the block opens a detection window of fixed length. It looks for a break, meaning the receive line held low for a number of consecutive cycles equal to a bit-time divisor multiplied by a bit count. A break seen inside the window selects the loader; otherwise the block boots into functional mode. In factory-restore mode, each rising edge of the external reset input produces a one-cycle restore request for the restore logic downstream.

Top module: `bootstrap_mode_ctrl`

## Requirements
- R1: While `por_rst` is high, every output is 0.
- R2: The strap code is captured at the 3rd rising clock edge after `por_rst` falls. Bit 2 of `strap_in` is the highest strap and bit 0 the lowest. Strap changes after that edge have no effect on any output.
- R3: Code 000 selects functional mode with four-wire JTAG (`boot_functional`=1, `dbg_swd`=0).
- R4: Code 001 selects functional mode with the two-wire serial debug port (`boot_functional`=1, `dbg_swd`=1), whatever `uart_rx` does.
- R5: Code 100 selects loader mode with four-wire JTAG (`boot_loader`=1, `dbg_swd`=0). The block holds this mode with no timeout until the next power-on reset.
- R6: With code 010, the block selects loader mode if `uart_rx`, as seen after its two-flop synchroniser, is low for at least BREAK_CYCLES = BAUD_DIV*BREAK_BITS consecutive samples inside the window. The window covers the WINDOW_CYCLES clock edges that follow the 4th edge after release.
- R7: With code 010 and no qualifying break (too short, before the window or running past its end), the block selects functional mode with four-wire JTAG.
- R8: Code 011 sets `boot_restore`. After the mode is final, each rising edge of `ext_reset_in` gives exactly one one-cycle `restore_req` pulse. The pulse appears three clock edges after the input edge is sampled.
- R9: In any mode other than factory restore, `restore_req` never asserts.
- R10: Codes 101, 110 and 111 select functional mode with four-wire JTAG and set `strap_invalid`. The listed codes leave `strap_invalid` at 0.
- R11: The mode flags change at edge 4 after release (edge 4+WINDOW_CYCLES for code 010), and `mode_valid` rises one edge later. All of these outputs then stay unchanged until the next power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| ext_reset_in | input | 1 | External reset pin; its rising edge requests a restore in restore mode |
| strap_in | input | 3 | Boot strap pins, bit 2 highest |
| uart_rx | input | 1 | UART receive line, idle high |
| mode_valid | output | 1 | Boot decision is final |
| boot_loader | output | 1 | UART loader mode selected |
| boot_functional | output | 1 | Functional mode selected |
| boot_restore | output | 1 | Factory-restore mode selected |
| dbg_swd | output | 1 | 1: two-wire serial debug port, 0: four-wire JTAG |
| strap_invalid | output | 1 | Captured strap code is not a listed code |
| restore_req | output | 1 | One-cycle factory-restore request |

## Verification
Suppose the wrong strap bit is captured or the synchroniser depth is off. The mode flags then show the wrong mode at the 4th edge after release, and the edge at which the flags change moves. A bench that samples that exact cycle sees both faults at once. An off-by-one in the break run counter or in the window limit flips the combined-mode result only for a break of exactly the threshold length, or one that just fits the end of the window. These boundary cases are therefore driven directly, and the result shows when the window closes. If capture were not frozen, or the restore edge detector were wrong, this would show a few cycles after the straps change or the external reset rises. The bench watches for that.

// File: rtl/bms_pkg.sv
package bms_pkg;

  typedef enum logic [2:0] {
    STRAP_FUNC_JTAG = 3'b000,
    STRAP_FUNC_SWD  = 3'b001,
    STRAP_COMBINED  = 3'b010,
    STRAP_RESTORE   = 3'b011,
    STRAP_LOADER    = 3'b100
  } strap_code_e;

  typedef struct packed {
    logic loader;
    logic functional;
    logic restore;
    logic swd;
    logic combined;
    logic invalid;
  } boot_dec_t;

  typedef enum logic [1:0] {
    ST_SETTLE,
    ST_DECODE,
    ST_WINDOW,
    ST_DONE
  } boot_state_e;

endpackage

// File: rtl/bms_sync.sv
module bms_sync #(
  parameter int          WIDTH     = 1,
  parameter int          STAGES    = 2,
  parameter [WIDTH-1:0]  RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RESET_VAL;
    else     stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RESET_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/bms_strap_decode.sv
module bms_strap_decode
  import bms_pkg::*;
(
  input  logic [2:0] code,
  output boot_dec_t  dec
);

  always_comb begin
    dec = '0;
    case (code)
      STRAP_FUNC_JTAG: dec.functional = 1'b1;
      STRAP_FUNC_SWD: begin
        dec.functional = 1'b1;
        dec.swd        = 1'b1;
      end
      STRAP_COMBINED:  dec.combined   = 1'b1;
      STRAP_RESTORE:   dec.restore    = 1'b1;
      STRAP_LOADER:    dec.loader     = 1'b1;
      default: begin
        dec.functional = 1'b1;
        dec.invalid    = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/bms_break_det.sv
module bms_break_det #(
  parameter int BREAK_CYCLES = 44
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rx_s,
  output logic hit,
  output logic seen
);

  localparam int RW = (BREAK_CYCLES > 1) ? $clog2(BREAK_CYCLES) : 1;
  localparam logic [RW-1:0] RUN_LAST = RW'(BREAK_CYCLES - 1);

  logic [RW-1:0] run_cnt;

  assign hit = en && !rx_s && (run_cnt == RUN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      seen    <= 1'b0;
    end else begin
      if (!en || rx_s)              run_cnt <= '0;
      else if (run_cnt != RUN_LAST) run_cnt <= run_cnt + 1'b1;
      if (hit) seen <= 1'b1;
    end
  end

  AST_SEEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    seen |=> seen); // R6

  AST_RUN_CLEARS_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    (en && rx_s) |=> (run_cnt == '0)); // R7

endmodule

// File: rtl/bootstrap_mode_ctrl.sv
module bootstrap_mode_ctrl
  import bms_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int BAUD_DIV      = 4,
  parameter int BREAK_BITS    = 11,
  parameter int WINDOW_CYCLES = 256
) (
  input  logic       clk,
  input  logic       por_rst,
  input  logic       ext_reset_in,
  input  logic [2:0] strap_in,
  input  logic       uart_rx,
  output logic       mode_valid,
  output logic       boot_loader,
  output logic       boot_functional,
  output logic       boot_restore,
  output logic       dbg_swd,
  output logic       strap_invalid,
  output logic       restore_req
);

  localparam int BREAK_CYCLES = BAUD_DIV * BREAK_BITS;
  localparam int SW = $clog2(SYNC_STAGES + 1);
  localparam int WW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SYNC_STAGES);
  localparam logic [WW-1:0] WIN_LAST    = WW'(WINDOW_CYCLES - 1);

  logic [2:0]    strap_s;
  logic          rx_s;
  logic          ext_s;
  logic          ext_prev;
  logic [2:0]    strap_q;
  boot_dec_t     dec;
  boot_state_e   state;
  logic [SW-1:0] settle_cnt;
  logic [WW-1:0] win_cnt;
  logic          decided;
  logic          brk_en;
  logic          brk_hit;
  logic          brk_seen;

  bms_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b000)) i_sync_strap (
    .clk(clk), .rst(por_rst), .d(strap_in), .q(strap_s));

  bms_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync_rx (
    .clk(clk), .rst(por_rst), .d(uart_rx), .q(rx_s));

  bms_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) i_sync_ext (
    .clk(clk), .rst(por_rst), .d(ext_reset_in), .q(ext_s));

  bms_strap_decode i_decode (.code(strap_q), .dec(dec));

  assign brk_en = (state == ST_WINDOW);

  bms_break_det #(.BREAK_CYCLES(BREAK_CYCLES)) i_break (
    .clk(clk), .rst(por_rst), .en(brk_en), .rx_s(rx_s),
    .hit(brk_hit), .seen(brk_seen));

  always_ff @(posedge clk) begin
    if (por_rst) begin
      state           <= ST_SETTLE;
      settle_cnt      <= '0;
      win_cnt         <= '0;
      strap_q         <= '0;
      decided         <= 1'b0;
      boot_loader     <= 1'b0;
      boot_functional <= 1'b0;
      boot_restore    <= 1'b0;
      dbg_swd         <= 1'b0;
      strap_invalid   <= 1'b0;
    end else begin
      case (state)
        ST_SETTLE: begin
          if (settle_cnt == SETTLE_LAST) begin
            strap_q <= strap_s;
            state   <= ST_DECODE;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        ST_DECODE: begin
          if (dec.combined) begin
            win_cnt <= '0;
            state   <= ST_WINDOW;
          end else begin
            boot_loader     <= dec.loader;
            boot_functional <= dec.functional;
            boot_restore    <= dec.restore;
            dbg_swd         <= dec.swd;
            strap_invalid   <= dec.invalid;
            decided         <= 1'b1;
            state           <= ST_DONE;
          end
        end
        ST_WINDOW: begin
          if (win_cnt == WIN_LAST) begin
            boot_loader     <= brk_seen || brk_hit;
            boot_functional <= !(brk_seen || brk_hit);
            decided         <= 1'b1;
            state           <= ST_DONE;
          end else begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por_rst) begin
      mode_valid  <= 1'b0;
      ext_prev    <= 1'b0;
      restore_req <= 1'b0;
    end else begin
      mode_valid  <= decided;
      ext_prev    <= ext_s;
      restore_req <= (state == ST_DONE) && boot_restore && ext_s && !ext_prev;
    end
  end

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (por_rst)
    mode_valid |-> ($countones({boot_loader, boot_functional, boot_restore}) == 1)); // R11

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (por_rst)
    mode_valid |=> (mode_valid && $stable({boot_loader, boot_functional, boot_restore, dbg_swd, strap_invalid}))); // R11

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (por_rst)
    (state == ST_DONE) |=> $stable(strap_q)); // R2

  AST_SWD_FUNC: assert property (@(posedge clk) disable iff (por_rst)
    dbg_swd |-> boot_functional); // R4

  AST_LOADER_JTAG: assert property (@(posedge clk) disable iff (por_rst)
    boot_loader |-> !dbg_swd); // R5

  AST_INVALID_FUNC: assert property (@(posedge clk) disable iff (por_rst)
    strap_invalid |-> (boot_functional && !dbg_swd)); // R10

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (por_rst)
    restore_req |=> !restore_req); // R8

  AST_PULSE_MODE: assert property (@(posedge clk) disable iff (por_rst)
    restore_req |-> boot_restore); // R9

endmodule

// File: tb/test_bootstrap_mode_ctrl.sv
module test_bootstrap_mode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int W   = 256;
  localparam int BRK = 44;

  logic       clk = 1'b0;
  logic       por_rst = 1'b1;
  logic       ext_reset_in = 1'b0;
  logic [2:0] strap_in = 3'b000;
  logic       uart_rx = 1'b1;
  logic       mode_valid, boot_loader, boot_functional, boot_restore;
  logic       dbg_swd, strap_invalid, restore_req;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bootstrap_mode_ctrl #(.SYNC_STAGES(2), .BAUD_DIV(4), .BREAK_BITS(11), .WINDOW_CYCLES(W))
    i_bootstrap_mode_ctrl (
      .clk(clk), .por_rst(por_rst), .ext_reset_in(ext_reset_in), .strap_in(strap_in),
      .uart_rx(uart_rx), .mode_valid(mode_valid), .boot_loader(boot_loader),
      .boot_functional(boot_functional), .boot_restore(boot_restore), .dbg_swd(dbg_swd),
      .strap_invalid(strap_invalid), .restore_req(restore_req));

  function automatic logic [5:0] outs();
    return {mode_valid, boot_loader, boot_functional, boot_restore, dbg_swd, strap_invalid};
  endfunction

  // flags {loader, functional, restore, swd, invalid}
  function automatic logic [4:0] exp_flags(input logic [2:0] code, input logic brk);
    case (code)
      3'd0: return 5'b01000;
      3'd1: return 5'b01010;
      3'd2: return brk ? 5'b10000 : 5'b01000;
      3'd3: return 5'b00100;
      3'd4: return 5'b10000;
      default: return 5'b01001;
    endcase
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // s: first edge with rx pin low, len: number of low edges (0 = idle)
  task automatic boot(input logic [2:0] code, input int s, input int len, input string req);
    int lo, hi, f, pulses;
    logic brk;
    logic [4:0] fl;
    @(negedge clk);
    por_rst = 1'b1; strap_in = code; uart_rx = 1'b1; ext_reset_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {outs()}, 6'b0);
    check("R1 reset pulse", {5'b0, restore_req}, 6'b0);
    lo = (s + 2 > 5) ? s + 2 : 5;
    hi = (s + len + 1 < 4 + W) ? s + len + 1 : 4 + W;
    brk = (len > 0) && (hi - lo + 1 >= BRK);
    fl = exp_flags(code, brk);
    f = (code == 3'd2) ? 4 + W : 4;
    por_rst = 1'b0;
    for (int e = 1; e <= f + 3; e++) begin
      uart_rx = !(len > 0 && e >= s && e < s + len);
      @(posedge clk);
      @(negedge clk);
      if (e == f - 1) check({req, " R11 before decision"}, outs(), 6'b0);
      if (e == f)     check({req, " R11 flags edge"}, {1'b0, fl}, outs());
      if (e == f + 1) check({req, " mode (R3 R4 R5 R6 R7 R8 R10)"}, outs(), {1'b1, fl});
    end
    uart_rx = 1'b1;
    strap_in = ~code;
    repeat (20) @(negedge clk);
    check({req, " R2 straps ignored"}, outs(), {1'b1, fl});
    pulses = 0;
    ext_reset_in = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (i == 3) ext_reset_in = 1'b0;
      @(negedge clk);
      if (restore_req) pulses++;
    end
    check({req, code == 3'd3 ? " R8 restore pulses" : " R9 no restore"},
          6'(pulses), (code == 3'd3) ? 6'd1 : 6'd0);
    check({req, " R5 R11 held"}, outs(), {1'b1, fl});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) boot(3'(c), 0, 0, "sweep idle rx");
    boot(3'd0, 1, 100000, "R3 rx low");
    boot(3'd1, 1, 100000, "R4 rx low");
    boot(3'd4, 1, 100000, "R5 rx low");
    boot(3'd6, 1, 100000, "R10 rx low");
    boot(3'd2, 1, 100000, "R6 long break");
    boot(3'd2, 10, BRK - 1, "R7 short break");
    boot(3'd2, 10, BRK, "R6 exact break");
    boot(3'd2, 10, BRK + 1, "R6 longer break");
    boot(3'd2, 1, 5, "R7 early low");
    boot(3'd2, W - 40, BRK, "R7 late break");
    boot(3'd2, W - 41, BRK, "R6 break at window end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule